// File: doc/BRIEF.md
# ADC Result Queue Bus Read Port

This block sits between an analog-to-digital converter's result path and a processor bus. A write side pushes conversion results into an internal queue. Each result carries a 12-bit value and the 5-bit number of the input channel it came from. The bus side reads the queue through a window of eight consecutive word addresses. Every one of those addresses returns the oldest stored result, so a burst of consecutive word reads drains consecutive entries in arrival order.

Each read returns a 32-bit word that holds an empty indicator, the channel number and the result value. Where these fields sit depends on a resolution input, which selects a 12-bit or a 10-bit layout. A second input chooses whether the channel number is reported or forced to zero. Read data is registered and appears in the cycle after the read strobe. When the queue is full, further results are dropped and a sticky overrun flag is set.

Top module: `adc_result_port`

## Requirements
- R1: A read strobe whose address is word-aligned (bits 1:0 zero) and lies in byte range 0x90..0xAF removes exactly one entry. The entry appears on `rd_data` on the clock edge that samples the strobe, so it can be sampled one cycle later. All eight aliases return entries in push order. `rd_data` is 0 after any cycle with no strobe.
- R2: When `mode_10bit`=0, the empty flag is at bit 31, the channel number at bits 20:16 and the result at bits 11:0. All other bits are 0.
- R3: When `mode_10bit`=1, the empty flag is at bit 15, the channel number at bits 14:10 and the low ten bits of the result at bits 9:0. Bits 31:16 are 0.
- R4: An in-window read while the queue is empty returns the empty flag as 1, with channel and result fields 0. It removes nothing.
- R5: With `chan_id_en`=1 the channel field carries the pushed channel number (0..31). With `chan_id_en`=0 it reads 0.
- R6: After reset the queue is empty, `overrun` is 0, `rd_data` is 0, and the first in-window read returns the empty flag as 1 with channel field 0.
- R7: Bus write strobes to any address leave the queue contents and `rd_data` unchanged.
- R8: The queue holds DEPTH entries (default 16). A push into a full queue with no pop in the same cycle is dropped and sets `overrun`. The flag stays set until reset.
- R9: A push and a successful pop in the same cycle both take effect. A push coinciding with a read of an empty queue is stored, while that read still reports empty.
- R10: A read strobe outside the window or not word-aligned returns 0 and removes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_valid | input | 1 | Push one result into the queue |
| push_value | input | 12 | Conversion result value |
| push_chan | input | 5 | Input channel number of the result |
| mode_10bit | input | 1 | 1 selects the 10-bit read layout |
| chan_id_en | input | 1 | 1 reports channel numbers in read words |
| rd_valid | input | 1 | Bus read strobe |
| rd_addr | input | ADDR_W (8) | Bus read byte address |
| bus_wr_valid | input | 1 | Bus write strobe (ignored) |
| bus_wr_addr | input | ADDR_W (8) | Bus write address (ignored) |
| bus_wr_data | input | 32 | Bus write data (ignored) |
| rd_data | output | 32 | Registered read word |
| overrun | output | 1 | Sticky full-queue drop flag |

## Verification
The hardest case to reach is the full boundary: a push arriving while the queue holds exactly DEPTH entries, both with and without a pop in the same cycle. The bench first fills the queue with DEPTH+1 back-to-back pushes, which forces one drop. It then drains the queue and checks that the values come back in order. Separately it applies a push and an in-window read in the same clock, once on a non-empty queue and once on an empty one. Then it confirms with later reads that the pushed entry was kept and that the empty read removed nothing.

// File: rtl/adc_rp_pkg.sv
package adc_rp_pkg;
  localparam int RES_W  = 12;
  localparam int CH_W   = 5;
  localparam int WORD_W = 32;

  typedef struct packed {
    logic [CH_W-1:0]  chan;
    logic [RES_W-1:0] value;
  } rp_entry_t;
endpackage

// File: rtl/adc_rp_fifo.sv
module adc_rp_fifo
  import adc_rp_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      push,
  input  rp_entry_t push_entry,
  input  logic      pop,
  output rp_entry_t head,
  output logic      empty,
  output logic      overrun
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  rp_entry_t     mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] count;
  logic          full, pop_en, wr_en;

  assign empty  = (count == '0);
  assign full   = (count == FULL);
  assign pop_en = pop && !empty;
  assign wr_en  = push && (!full || pop_en);
  assign head   = mem[rptr];

  // storage without reset so it can map onto distributed RAM
  always_ff @(posedge clk) begin
    if (wr_en) mem[wptr] <= push_entry;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr    <= '0;
      rptr    <= '0;
      count   <= '0;
      overrun <= 1'b0;
    end else begin
      if (wr_en)  wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
      if (pop_en) rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
      case ({wr_en, pop_en})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (push && !wr_en) overrun <= 1'b1;
    end
  end

  p_count_bound_r8: assert property (@(posedge clk) disable iff (rst)
    count <= FULL);
  p_overrun_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    overrun |=> overrun);
  p_no_pop_empty_r4: assert property (@(posedge clk) disable iff (rst)
    (empty && pop && !push) |=> empty);
  p_push_pop_r9: assert property (@(posedge clk) disable iff (rst)
    (push && pop && !empty) |=> $stable(count));
endmodule

// File: rtl/adc_rp_decode.sv
module adc_rp_decode #(
  parameter int ADDR_W    = 8,
  parameter int WIN_BASE  = 'h90,
  parameter int WIN_WORDS = 8
) (
  input  logic              rd_valid,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              hit
);
  localparam logic [ADDR_W:0] LO = (ADDR_W+1)'(WIN_BASE);
  localparam logic [ADDR_W:0] HI = (ADDR_W+1)'(WIN_BASE + 4 * WIN_WORDS);

  logic [ADDR_W:0] a_ext;
  assign a_ext = {1'b0, rd_addr};
  assign hit = rd_valid && (rd_addr[1:0] == 2'b00) && (a_ext >= LO) && (a_ext < HI);
endmodule

// File: rtl/adc_rp_pack.sv
module adc_rp_pack
  import adc_rp_pkg::*;
(
  input  rp_entry_t         ent,
  input  logic              empty,
  input  logic              mode_10bit,
  input  logic              chan_id_en,
  output logic [WORD_W-1:0] word
);
  logic [CH_W-1:0]  ch;
  logic [RES_W-1:0] val;

  assign ch  = (empty || !chan_id_en) ? '0 : ent.chan;
  assign val = empty ? '0 : ent.value;

  always_comb begin
    word = '0;
    if (mode_10bit) begin
      word[15]    = empty;
      word[14:10] = ch;
      word[9:0]   = val[9:0];
    end else begin
      word[31]    = empty;
      word[20:16] = ch;
      word[11:0]  = val;
    end
  end
endmodule

// File: rtl/adc_result_port.sv
module adc_result_port
  import adc_rp_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int ADDR_W    = 8,
  parameter int WIN_BASE  = 'h90,
  parameter int WIN_WORDS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_valid,
  input  logic [RES_W-1:0]  push_value,
  input  logic [CH_W-1:0]   push_chan,
  input  logic              mode_10bit,
  input  logic              chan_id_en,
  input  logic              rd_valid,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              bus_wr_valid,
  input  logic [ADDR_W-1:0] bus_wr_addr,
  input  logic [WORD_W-1:0] bus_wr_data,
  output logic [WORD_W-1:0] rd_data,
  output logic              overrun
);
  rp_entry_t         push_entry, head;
  logic              hit, q_empty;
  logic [WORD_W-1:0] packed_word;
  logic              unused_wr;

  // the window is read-only: write strobes are absorbed here
  assign unused_wr  = ^{bus_wr_valid, bus_wr_addr, bus_wr_data};
  assign push_entry = '{chan: push_chan, value: push_value};

  adc_rp_decode #(.ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .WIN_WORDS(WIN_WORDS)) u_decode (
    .rd_valid (rd_valid),
    .rd_addr  (rd_addr),
    .hit      (hit)
  );

  adc_rp_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk        (clk),
    .rst        (rst),
    .push       (push_valid),
    .push_entry (push_entry),
    .pop        (hit),
    .head       (head),
    .empty      (q_empty),
    .overrun    (overrun)
  );

  adc_rp_pack u_pack (
    .ent        (head),
    .empty      (q_empty),
    .mode_10bit (mode_10bit),
    .chan_id_en (chan_id_en),
    .word       (packed_word)
  );

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= hit ? packed_word : '0;
  end

  p_miss_zero_r10: assert property (@(posedge clk) disable iff (rst)
    !hit |=> (rd_data == '0));
  p_empty_word_r4: assert property (@(posedge clk) disable iff (rst)
    (hit && q_empty) |=> (rd_data == ($past(mode_10bit) ? 32'h0000_8000 : 32'h8000_0000)));
  p_layout_12_r2: assert property (@(posedge clk) disable iff (rst)
    (hit && !mode_10bit) |=> (rd_data[30:21] == '0 && rd_data[15:12] == '0));
  p_layout_10_r3: assert property (@(posedge clk) disable iff (rst)
    (hit && mode_10bit) |=> (rd_data[31:16] == '0));
endmodule

// File: tb/adc_result_port_bench.sv
module adc_result_port_bench;
  localparam int DEPTH = 16;

  logic        clk = 0, rst = 1;
  logic        push_valid = 0, mode_10bit = 0, chan_id_en = 1, rd_valid = 0;
  logic [11:0] push_value = 0;
  logic [4:0]  push_chan = 0;
  logic [7:0]  rd_addr = 0, bus_wr_addr = 0;
  logic        bus_wr_valid = 0;
  logic [31:0] bus_wr_data = 0, rd_data;
  logic        overrun;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  adc_result_port u_adc_result_port (
    .clk(clk), .rst(rst), .push_valid(push_valid), .push_value(push_value),
    .push_chan(push_chan), .mode_10bit(mode_10bit), .chan_id_en(chan_id_en),
    .rd_valid(rd_valid), .rd_addr(rd_addr), .bus_wr_valid(bus_wr_valid),
    .bus_wr_addr(bus_wr_addr), .bus_wr_data(bus_wr_data),
    .rd_data(rd_data), .overrun(overrun)
  );

  // {op(0 push,1 read), addr, value, chan, mode_10bit, chan_id_en, expected word}
  localparam logic [60:0] VEC [15] = '{
    {2'd0, 8'h00, 12'hABC, 5'd3,  1'b0, 1'b1, 32'h0},
    {2'd0, 8'h00, 12'h123, 5'd31, 1'b0, 1'b1, 32'h0},
    {2'd0, 8'h00, 12'hFFF, 5'd0,  1'b0, 1'b1, 32'h0},
    {2'd0, 8'h00, 12'h456, 5'd17, 1'b0, 1'b1, 32'h0},
    {2'd1, 8'h90, 12'h0,   5'd0,  1'b0, 1'b1, 32'h0003_0ABC},
    {2'd1, 8'hAC, 12'h0,   5'd0,  1'b0, 1'b1, 32'h001F_0123},
    {2'd1, 8'h94, 12'h0,   5'd0,  1'b1, 1'b1, 32'h0000_03FF},
    {2'd1, 8'h98, 12'h0,   5'd0,  1'b0, 1'b0, 32'h0000_0456},
    {2'd1, 8'h9C, 12'h0,   5'd0,  1'b0, 1'b1, 32'h8000_0000},
    {2'd1, 8'h9C, 12'h0,   5'd0,  1'b1, 1'b1, 32'h0000_8000},
    {2'd0, 8'h00, 12'h2A5, 5'd9,  1'b0, 1'b1, 32'h0},
    {2'd1, 8'hB0, 12'h0,   5'd0,  1'b0, 1'b1, 32'h0},
    {2'd1, 8'h91, 12'h0,   5'd0,  1'b0, 1'b1, 32'h0},
    {2'd1, 8'h8C, 12'h0,   5'd0,  1'b0, 1'b1, 32'h0},
    {2'd1, 8'hA0, 12'h0,   5'd0,  1'b1, 1'b1, 32'h0000_26A5}
  };

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic push(input logic [11:0] v, input logic [4:0] c);
    @(negedge clk);
    push_valid = 1; push_value = v; push_chan = c;
    @(negedge clk);
    push_valid = 0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    rd_valid = 1; rd_addr = a;
    @(negedge clk);
    rd_valid = 0;
    check(rd_data, exp, req);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R6: reset state
    check(rd_data, 32'h0, "R6 rd_data");
    check({31'h0, overrun}, 32'h0, "R6 overrun");
    rd(8'h90, 32'h8000_0000, "R6 first read empty");

    // table walk: R1 R2 R3 R4 R5 R10
    for (int i = 0; i < 15; i++) begin
      mode_10bit = VEC[i][33];
      chan_id_en = VEC[i][32];
      if (VEC[i][60:59] == 2'd0) push(VEC[i][50:39], VEC[i][38:34]);
      else rd(VEC[i][58:51], VEC[i][31:0], "R1/R2/R3/R4/R5/R10 table");
    end
    mode_10bit = 0; chan_id_en = 1;
    @(negedge clk);
    check(rd_data, 32'h0, "R1 idle cycle zero");

    // R7: bus writes ignored
    push(12'h777, 5'd5);
    @(negedge clk);
    bus_wr_valid = 1; bus_wr_addr = 8'h90; bus_wr_data = 32'hFFFF_FFFF;
    @(negedge clk);
    bus_wr_addr = 8'hA4;
    @(negedge clk);
    bus_wr_valid = 0;
    check(rd_data, 32'h0, "R7 rd_data unchanged");
    rd(8'hA8, 32'h0005_0777, "R7 entry intact");
    rd(8'h90, 32'h8000_0000, "R7 no extra entry");

    // R8: fill past full
    for (int i = 0; i <= DEPTH; i++) push(12'(i), 5'(i));
    check({31'h0, overrun}, 32'h1, "R8 overrun set");
    for (int i = 0; i < DEPTH; i++)
      rd(8'(8'h90 + 4 * (i % 8)), {11'h0, 5'(i), 4'h0, 12'(i)}, "R8 drain order");
    rd(8'h94, 32'h8000_0000, "R8 dropped entry absent");
    check({31'h0, overrun}, 32'h1, "R8 overrun sticky");

    // R9: push + pop same cycle, non-empty and empty
    push(12'h0A1, 5'd1);
    @(negedge clk);
    push_valid = 1; push_value = 12'h0B2; push_chan = 5'd2;
    rd_valid = 1; rd_addr = 8'h90;
    @(negedge clk);
    push_valid = 0; rd_valid = 0;
    check(rd_data, 32'h0001_00A1, "R9 pop with push");
    rd(8'h94, 32'h0002_00B2, "R9 pushed kept");
    @(negedge clk);
    push_valid = 1; push_value = 12'h0C3; push_chan = 5'd4;
    rd_valid = 1; rd_addr = 8'h98;
    @(negedge clk);
    push_valid = 0; rd_valid = 0;
    check(rd_data, 32'h8000_0000, "R9 empty read with push");
    rd(8'h9C, 32'h0004_00C3, "R9 push into empty kept");

    // R6: reset clears overrun
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    check({31'h0, overrun}, 32'h0, "R6 overrun cleared");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule